// File: doc/BRIEF.md
# Line-Buffer Video Scan Doubler

This block turns a slow progressive video stream into one with twice the line count and twice the pixel count per line. It needs no frame store. Each incoming line is captured into one of four small line RAMs, taken in rotation. The output side replays a finished line on two consecutive output lines. On each of those lines it shows every stored pixel for two output pixel slots. A 320 by 200 picture at a line rate of about 15.7 kHz therefore comes out as 640 by 400 at about 31 kHz. The frame period is the same on both sides, so a fixed, small amount of line storage is enough to absorb the difference in rates.

The input side is a pixel strobe with a 12-bit pixel, an end-of-line pulse and a start-of-frame pulse. The block runs on the fast output clock. Slow input pixels arrive as one-cycle strobes on that clock, so no clock-domain crossing sits inside the block. Output timing is produced elsewhere and arrives as an x coordinate, a y coordinate and an active flag. The block answers with the pixel for that position one clock later.

Top module: `sd_scan_doubler`

## Requirements
- R1: While reset is high and on the cycle after it, `out_pix` is zero; reset sets the write bank index and the write position to zero.
- R2: A strobe with the write position below 320 writes exactly one line RAM, the one chosen by the current write bank index; with no strobe, no line RAM is written.
- R3: The write address is the number of strobes accepted since the last line or frame pulse; strobes after the 320th in a line are ignored and leave the stored line unchanged.
- R4: `in_hsync` advances the write bank index by one modulo 4 and restarts the write position at zero.
- R5: `in_vsync` returns the write bank index and write position to zero, and wins over `in_hsync` in the same cycle.
- R6: The read bank is `out_y[2:1]` and the read address is `out_x >> 1`, so each stored pixel covers a 2 by 2 block of output positions.
- R7: `out_pix` reflects the `out_x`/`out_y`/`out_active` sampled on the previous clock edge (one cycle of latency).
- R8: When `out_active` is low, or `out_x >> 1` is 320 or more, `out_pix` is zero.
- R9: When the read bank equals the current write bank, `out_pix` is zero, so a line being filled is never shown.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Output pixel clock; all logic is on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_strobe | input | 1 | One-cycle strobe marking a valid input pixel |
| in_pix | input | 12 | Input pixel value |
| in_hsync | input | 1 | One-cycle pulse ending an input line |
| in_vsync | input | 1 | One-cycle pulse starting an input frame |
| out_x | input | 10 | Output horizontal position |
| out_y | input | 9 | Output vertical position |
| out_active | input | 1 | High inside the visible output area |
| out_pix | output | 12 | Doubled output pixel, zero when blanked |

## Verification
The bench aims at the places where a doubler quietly goes wrong. Extra strobes past the end of a line would wrap around and overwrite its first pixels, or spill into the last address. A read of the bank under write would show torn data instead of black. A frame pulse arriving mid-line must leave the next line stored from address zero, and a frame pulse arriving together with a line pulse must not advance the bank. Reads at x = 638/639 and x = 640, reads with `out_active` low, and the wrap of the bank index from 3 back to 0 expose off-by-one addressing, a missing blanking gate, or a wrong latency. Each of these would show up as a wrong pixel in a single sampled position.

// File: rtl/sd_pkg.sv
package sd_pkg;
    localparam int IN_W    = 320;
    localparam int IN_H    = 200;
    localparam int PIX_W   = 12;
    localparam int NBANKS  = 4;     // power of two
    localparam int OUT_W   = 2 * IN_W;
    localparam int OUT_H   = 2 * IN_H;
    localparam int XW      = $clog2(OUT_W);
    localparam int YW      = $clog2(OUT_H);
    localparam int ADDR_W  = $clog2(IN_W);
    localparam int WX_W    = $clog2(IN_W + 1);
    localparam int BANK_W  = $clog2(NBANKS);

    typedef logic [PIX_W-1:0]  pix_t;
    typedef logic [BANK_W-1:0] bank_t;
    typedef logic [ADDR_W-1:0] addr_t;

    typedef struct packed {
        logic  valid;
        bank_t bank;
    } rd_stage_t;

    function automatic bank_t next_bank(input bank_t b);
        return (int'(b) == NBANKS - 1) ? '0 : bank_t'(b + 1'b1);
    endfunction
endpackage

// File: rtl/sd_bank_decode.sv
module sd_bank_decode
    import sd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              master_we,
    input  bank_t             sel,
    output logic [NBANKS-1:0] bank_we
);
    for (genvar i = 0; i < NBANKS; i++) begin : g_dec
        assign bank_we[i] = master_we && (sel == bank_t'(i));
    end

    AST_ONE_BANK_WRITTEN: assert property (@(posedge clk) disable iff (rst)
        master_we |-> $countones(bank_we) == 1) else $error("one-hot"); // R2
    AST_NO_STRAY_WRITE: assert property (@(posedge clk) disable iff (rst)
        !master_we |-> $countones(bank_we) == 0) else $error("stray"); // R2
endmodule

// File: rtl/sd_line_ram.sv
module sd_line_ram
    import sd_pkg::*;
(
    input  logic  clk,
    input  logic  we,
    input  addr_t wa,
    input  pix_t  wd,
    input  addr_t ra,
    output pix_t  rd
);
    pix_t mem [IN_W];

    always_ff @(posedge clk) begin
        if (we) mem[wa] <= wd;
        rd <= mem[ra];
    end
endmodule

// File: rtl/sd_write_ctrl.sv
module sd_write_ctrl
    import sd_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            in_strobe,
    input  logic            in_hsync,
    input  logic            in_vsync,
    output logic [WX_W-1:0] wr_x,
    output bank_t           wr_bank,
    output logic            master_we
);
    localparam logic [WX_W-1:0] LINE_END = WX_W'(IN_W);

    assign master_we = in_strobe && (wr_x < LINE_END);

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_x    <= '0;
            wr_bank <= '0;
        end else if (in_vsync) begin
            wr_x    <= '0;
            wr_bank <= '0;
        end else if (in_hsync) begin
            wr_x    <= '0;
            wr_bank <= next_bank(wr_bank);
        end else if (master_we) begin
            wr_x    <= wr_x + 1'b1;
        end
    end

    AST_BANK_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        in_hsync && !in_vsync |=> wr_bank == next_bank($past(wr_bank))) else $error("advance"); // R4
    AST_FRAME_RESTART: assert property (@(posedge clk) disable iff (rst)
        in_vsync |=> wr_bank == '0 && wr_x == '0) else $error("frame"); // R5
    AST_ADDR_BOUND: assert property (@(posedge clk) disable iff (rst)
        wr_x <= LINE_END) else $error("bound"); // R3
endmodule

// File: rtl/sd_scan_doubler.sv
module sd_scan_doubler
    import sd_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_strobe,
    input  logic [PIX_W-1:0]     in_pix,
    input  logic                 in_hsync,
    input  logic                 in_vsync,
    input  logic [XW-1:0]        out_x,
    input  logic [YW-1:0]        out_y,
    input  logic                 out_active,
    output logic [PIX_W-1:0]     out_pix
);
    logic [WX_W-1:0]   wr_x;
    bank_t             wr_bank;
    logic              master_we;
    logic [NBANKS-1:0] bank_we;
    pix_t              rdata [NBANKS];

    sd_write_ctrl u_wctl (
        .clk(clk), .rst(rst), .in_strobe(in_strobe), .in_hsync(in_hsync),
        .in_vsync(in_vsync), .wr_x(wr_x), .wr_bank(wr_bank), .master_we(master_we)
    );

    sd_bank_decode u_dec (
        .clk(clk), .rst(rst), .master_we(master_we), .sel(wr_bank), .bank_we(bank_we)
    );

    // Read request decode
    addr_t     rd_addr;
    bank_t     rd_bank;
    logic      in_line;
    rd_stage_t rd_q;

    assign rd_addr = out_x[XW-1:1];
    assign rd_bank = out_y[BANK_W:1];
    assign in_line = rd_addr < addr_t'(IN_W);

    for (genvar i = 0; i < NBANKS; i++) begin : g_bank
        sd_line_ram u_ram (
            .clk(clk), .we(bank_we[i]), .wa(wr_x[ADDR_W-1:0]), .wd(in_pix),
            .ra(rd_addr), .rd(rdata[i])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q <= '0;
        end else begin
            rd_q.valid <= out_active && in_line && (rd_bank != wr_bank);
            rd_q.bank  <= rd_bank;
        end
    end

    assign out_pix = rd_q.valid ? rdata[rd_q.bank] : '0;

    AST_BLANK_ZERO: assert property (@(posedge clk) disable iff (rst)
        !out_active |=> out_pix == '0) else $error("blank"); // R8
    AST_NO_TORN_READ: assert property (@(posedge clk) disable iff (rst)
        out_active && rd_bank == wr_bank |=> out_pix == '0) else $error("torn"); // R9
    AST_STEADY_OUTPUT: assert property (@(posedge clk) disable iff (rst)
        !in_strobe && $stable(out_x) && $stable(out_y) && $stable(out_active)
        && $stable(wr_bank) |=> $stable(out_pix)) else $error("steady"); // R7
endmodule

// File: tb/sd_scan_doubler_test.sv
module sd_scan_doubler_test;
    import sd_pkg::*;

    logic clk = 0;
    logic rst = 1;
    logic in_strobe = 0, in_hsync = 0, in_vsync = 0, out_active = 0;
    logic [PIX_W-1:0] in_pix = '0;
    logic [XW-1:0] out_x = '0;
    logic [YW-1:0] out_y = '0;
    logic [PIX_W-1:0] out_pix;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [PIX_W-1:0] mdl [NBANKS][IN_W];
    int mwb = 0;
    int mx  = 0;

    always #2.5 clk = ~clk;

    sd_scan_doubler uut (
        .clk(clk), .rst(rst), .in_strobe(in_strobe), .in_pix(in_pix),
        .in_hsync(in_hsync), .in_vsync(in_vsync), .out_x(out_x), .out_y(out_y),
        .out_active(out_active), .out_pix(out_pix)
    );

    localparam int NRD = 13;
    // {y, x, active}
    localparam logic [19:0] RD_TBL [NRD] = '{
        {9'd2,   10'd0,   1'b1}, {9'd2,   10'd1,   1'b1}, {9'd3,   10'd1,   1'b1},
        {9'd4,   10'd100, 1'b1}, {9'd5,   10'd101, 1'b1}, {9'd6,   10'd638, 1'b1},
        {9'd7,   10'd639, 1'b1}, {9'd2,   10'd639, 1'b1}, {9'd0,   10'd10,  1'b1},
        {9'd10,  10'd5,   1'b1}, {9'd4,   10'd4,   1'b0}, {9'd2,   10'd640, 1'b1},
        {9'd399, 10'd20,  1'b1}
    };

    function automatic logic [PIX_W-1:0] pat(input int line, input int x);
        return PIX_W'((line << 9) ^ (x * 3) ^ 12'h05A);
    endfunction

    function automatic logic [PIX_W-1:0] expect_pix(input int y, input int x, input bit act);
        int b = (y >> 1) % NBANKS;
        int a = x >> 1;
        if (!act || a >= IN_W) return '0;
        if (b == mwb) return '0;
        return mdl[b][a];
    endfunction

    task automatic check(input string req, input logic [PIX_W-1:0] act, input logic [PIX_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic put_pix(input logic [PIX_W-1:0] v);
        @(negedge clk);
        in_strobe = 1; in_pix = v;
        @(posedge clk); #1;
        in_strobe = 0;
        if (mx < IN_W) begin mdl[mwb][mx] = v; mx++; end
    endtask

    task automatic sync(input bit h, input bit v);
        @(negedge clk);
        in_hsync = h; in_vsync = v;
        @(posedge clk); #1;
        in_hsync = 0; in_vsync = 0;
        if (v) mwb = 0; else if (h) mwb = (mwb + 1) % NBANKS;
        mx = 0;
    endtask

    task automatic write_line(input int line, input int n);
        for (int x = 0; x < n; x++) put_pix(x < IN_W ? pat(line, x) : 12'hABC);
        sync(1, 0);
    endtask

    task automatic rd(input string req, input int y, input int x, input bit act);
        logic [PIX_W-1:0] e;
        @(negedge clk);
        out_y = YW'(y); out_x = XW'(x); out_active = act;
        e = expect_pix(y, x, act);
        @(posedge clk); #1;
        check(req, out_pix, e);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        // R1: reset state, outputs blanked even with active request
        out_active = 1; out_y = 9'd2; out_x = 10'd4;
        repeat (3) @(posedge clk);
        #1 check("R1 during reset", out_pix, '0);
        @(negedge clk); rst = 0; out_active = 0;
        @(posedge clk); #1 check("R1 after reset", out_pix, '0);

        // Fill banks 0..3; line 1 gets 5 extra strobes (R3 ignored)
        sync(0, 1);
        write_line(0, IN_W);
        write_line(1, IN_W + 5);
        write_line(2, IN_W);
        write_line(3, IN_W);
        // R4: bank index wrapped to 0 after four lines

        // Table walk: R6 doubling, R8 blanking, R9 collision, R3 overflow
        for (int i = 0; i < NRD; i++)
            rd("R6/R8/R9 table", int'(RD_TBL[i][19:11]), int'(RD_TBL[i][10:1]), RD_TBL[i][0]);

        // R3: last address of line 1 kept its own value, not the extra pixels
        rd("R3 overflow ignored", 3, 639, 1'b1);
        check("R3 last pixel", out_pix, pat(1, 319));
        // R6: both halves of a doubled pixel agree
        rd("R6 left", 4, 200, 1'b1);
        rd("R6 right", 5, 201, 1'b1);
        check("R6 value", out_pix, pat(2, 100));

        // R2/R4: new line goes into bank 0, bank index moves to 1
        write_line(4, IN_W);
        rd("R2 bank0 new line", 0, 2, 1'b1);
        check("R2 bank0 content", out_pix, pat(4, 1));
        rd("R9 bank1 now writing", 2, 2, 1'b1);
        check("R9 blocked", out_pix, '0);

        // R7: one cycle of latency: data then immediate blank
        rd("R7 data", 6, 8, 1'b1);
        rd("R7 next blank", 6, 8, 1'b0);

        // R5: frame pulse mid-line restarts at bank 0, address 0
        for (int x = 0; x < 10; x++) put_pix(12'hF00);
        sync(0, 1);
        write_line(5, IN_W);
        rd("R5 restart address", 1, 20, 1'b1);
        check("R5 line5 at addr10", out_pix, pat(5, 10));

        // R5: vsync wins over hsync in the same cycle
        sync(1, 1);
        write_line(6, IN_W);
        rd("R5 priority", 0, 30, 1'b1);
        check("R5 line6 in bank0", out_pix, pat(6, 15));

        // R4: wrap 3 -> 0 again
        sync(1, 0); sync(1, 0); sync(1, 0);
        rd("R4 wrap blocks bank0", 0, 30, 1'b1);
        check("R4 bank0 current", out_pix, '0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule